// File: doc/BRIEF.md
# Prioritized UART Interrupt Identifier

This block merges the four interrupt causes of a UART into one interrupt request line and a 3-bit identification code that software reads to learn why it was interrupted. The four causes are:

- receiver line errors (overrun, parity, framing, break);
- a received character waiting;
- the transmit holding register becoming empty;
- a change on one of the four modem-control inputs.

Each cause is latched as pending when its raw event is seen. It stays pending until the clearing access that belongs to it: a read of the line status register, a read of the receive buffer, a write of the transmit holding register, or a read of the modem status register. The transmit-empty cause has one extra way to clear. Reading the identification register clears it, but only when that same read reports transmit-empty as the cause.

A per-source enable mask decides which pending causes are reported and which can raise the request line. The mask never erases a pending cause. The identification code is a pure function of the registered pending state and the mask. The clearing strobes are expected to come from the register-decode logic of the surrounding UART.

Top module: `uart_irq_ident`

## Requirements
- R1: Out of reset, and whenever no source is both pending and enabled, `irq_o` is 0 and `id_o` reads 001.
- R2: While `irq_o` is 1, bit 0 of `id_o` is 0. The codes are: line status 110, received data 100, transmit empty 010, modem status 000.
- R3: When several sources are pending and enabled, `id_o` reports one of them in fixed priority order: line status first, then received data, then transmit empty, then modem status last.
- R4: Any asserted bit of `ls_cond_i` makes the line-status source pending. The bits are overrun, parity, framing and break, in any order. The source stays pending until a cycle with `rd_lsr_i` high.
- R5: `rx_ready_i` makes the received-data source pending until a cycle with `rd_rbr_i` high.
- R6: `tx_empty_i` makes the transmit-empty source pending until a cycle with `wr_thr_i` high.
- R7: A cycle with `rd_iir_i` high clears the transmit-empty source only if `id_o` reads 010 in that same cycle. A read that reports another code leaves it pending, and so does a read made while the source is disabled. An event of higher priority arriving in the read cycle does not stop the clear.
- R8: Any asserted bit of `ms_chg_i` makes the modem source pending until a cycle with `rd_msr_i` high. The bits are changes on clear-to-send, data-set-ready, ring indicator and carrier detect.
- R9: Each bit of `en_i` enables one source: bit 0 line status, bit 1 received data, bit 2 transmit empty, bit 3 modem status. A disabled source is neither reported nor drives `irq_o`, but it stays pending. Enabling it later raises the interrupt with its code.
- R10: An event seen at a clock edge raises `irq_o` and `id_o` right after that edge. A clearing strobe seen at a clock edge drops the pending state right after that edge, and not before it.
- R11: If an event and its own clearing strobe arrive in the same cycle, the source is left pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en_i | input | 4 | Source enable mask (bit 0 line status, 1 received data, 2 transmit empty, 3 modem) |
| ls_cond_i | input | 4 | Receiver error conditions: overrun, parity, framing, break |
| rx_ready_i | input | 1 | Received character available |
| tx_empty_i | input | 1 | Transmit holding register empty event |
| ms_chg_i | input | 4 | Change flags for the four modem inputs |
| rd_lsr_i | input | 1 | Line status register read strobe |
| rd_rbr_i | input | 1 | Receive buffer read strobe |
| wr_thr_i | input | 1 | Transmit holding register write strobe |
| rd_iir_i | input | 1 | Identification register read strobe |
| rd_msr_i | input | 1 | Modem status register read strobe |
| irq_o | output | 1 | Interrupt request |
| id_o | output | 3 | Identification code |

## Verification
The properties assume every strobe and event input is synchronous to `clk` and lasts exactly the cycles the bus or the status logic means it to. A register access is treated as one cycle wide, so a strobe held high would clear again in every cycle. The properties also assume that `id_o` is read in the same cycle that `rd_iir_i` is high.

The bench drives all inputs just after the falling edge and drops every strobe after a single rising edge. It checks the outputs at the following falling edge, so every access is one clean cycle. It also raises events together with strobes on purpose, to reach the same-cycle cases.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

    localparam int unsigned NUM_SRC = 4;
    localparam int unsigned IDX_W   = $clog2(NUM_SRC);

    // Source indices, in descending priority
    localparam int unsigned SRC_LINE = 0;
    localparam int unsigned SRC_RXD  = 1;
    localparam int unsigned SRC_TXE  = 2;
    localparam int unsigned SRC_MDM  = 3;

    localparam logic [2:0] ID_NONE = 3'b001;

    // Code of a source: priority rank inverted, shifted left, bit 0 clear
    function automatic logic [2:0] src_code(input int unsigned idx);
        logic [IDX_W-1:0] rank;
        rank = IDX_W'(NUM_SRC - 1 - idx);
        return {rank, 1'b0};
    endfunction

    typedef struct packed {
        logic pend;
    } pend_state_t;

endpackage

// File: rtl/irq_pend_cell.sv
module irq_pend_cell
    import uart_irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic pend_o
);

    pend_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr_i)
            st_d.pend = 1'b0;
        if (set_i)
            st_d.pend = 1'b1;   // a new event outranks a simultaneous clear
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign pend_o = st_q.pend;

    assert_set_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> pend_o);

    assert_clear_next_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !set_i) |=> !pend_o);

    assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_i && !set_i) |=> $stable(pend_o));

endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick
    import uart_irq_pkg::*;
#(
    parameter int unsigned N = NUM_SRC
) (
    input  logic [N-1:0] active_i,
    output logic [2:0]   id_o,
    output logic         any_o
);

    always_comb begin
        id_o  = ID_NONE;
        any_o = 1'b0;
        // Walk from lowest to highest priority so the highest wins
        for (int i = N - 1; i >= 0; i--) begin
            if (active_i[i]) begin
                id_o  = src_code(i);
                any_o = 1'b1;
            end
        end
    end

endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
    import uart_irq_pkg::*;
#(
    parameter int unsigned LS_W = 4,
    parameter int unsigned MS_W = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [3:0]      en_i,
    input  logic [LS_W-1:0] ls_cond_i,
    input  logic            rx_ready_i,
    input  logic            tx_empty_i,
    input  logic [MS_W-1:0] ms_chg_i,
    input  logic            rd_lsr_i,
    input  logic            rd_rbr_i,
    input  logic            wr_thr_i,
    input  logic            rd_iir_i,
    input  logic            rd_msr_i,
    output logic            irq_o,
    output logic [2:0]      id_o
);

    localparam logic [2:0] ID_TXE = src_code(SRC_TXE);
    localparam logic [2:0] ID_LS  = src_code(SRC_LINE);

    logic [NUM_SRC-1:0] set_vec, clr_vec, pend_vec, active_vec;
    logic               any_active;

    always_comb begin
        set_vec          = '0;
        set_vec[SRC_LINE] = |ls_cond_i;
        set_vec[SRC_RXD]  = rx_ready_i;
        set_vec[SRC_TXE]  = tx_empty_i;
        set_vec[SRC_MDM]  = |ms_chg_i;

        clr_vec          = '0;
        clr_vec[SRC_LINE] = rd_lsr_i;
        clr_vec[SRC_RXD]  = rd_rbr_i;
        // the code being read this cycle decides, not the next one
        clr_vec[SRC_TXE]  = wr_thr_i | (rd_iir_i && (id_o == ID_TXE));
        clr_vec[SRC_MDM]  = rd_msr_i;
    end

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
        irq_pend_cell u_cell (
            .clk   (clk),
            .rst_n (rst_n),
            .set_i (set_vec[g]),
            .clr_i (clr_vec[g]),
            .pend_o(pend_vec[g])
        );
    end

    assign active_vec = pend_vec & en_i;

    irq_prio_pick #(.N(NUM_SRC)) u_pick (
        .active_i(active_vec),
        .id_o    (id_o),
        .any_o   (any_active)
    );

    assign irq_o = any_active;

    assert_idle_code_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_o |-> (id_o == ID_NONE));

    assert_code_bit0_R2: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> !id_o[0]);

    assert_line_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_vec[SRC_LINE] && en_i[SRC_LINE]) |-> (id_o == ID_LS));

    assert_iir_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_iir_i && id_o == ID_TXE && !tx_empty_i) |=> !pend_vec[SRC_TXE]);

    assert_iir_keep_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_vec[SRC_TXE] && rd_iir_i && id_o != ID_TXE && !wr_thr_i)
            |=> pend_vec[SRC_TXE]);

    assert_mask_keep_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_vec[SRC_RXD] && !en_i[SRC_RXD] && !rd_rbr_i) |=> pend_vec[SRC_RXD]);

endmodule

// File: tb/uart_irq_ident_test.sv
`timescale 1ns/1ps
module uart_irq_ident_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] en_i = 4'hF;
    logic [3:0] ls_cond_i = '0;
    logic       rx_ready_i = 1'b0;
    logic       tx_empty_i = 1'b0;
    logic [3:0] ms_chg_i = '0;
    logic       rd_lsr_i = 1'b0;
    logic       rd_rbr_i = 1'b0;
    logic       wr_thr_i = 1'b0;
    logic       rd_iir_i = 1'b0;
    logic       rd_msr_i = 1'b0;
    logic       irq_o;
    logic [2:0] id_o;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    uart_irq_ident uut (
        .clk(clk), .rst_n(rst_n), .en_i(en_i), .ls_cond_i(ls_cond_i),
        .rx_ready_i(rx_ready_i), .tx_empty_i(tx_empty_i), .ms_chg_i(ms_chg_i),
        .rd_lsr_i(rd_lsr_i), .rd_rbr_i(rd_rbr_i), .wr_thr_i(wr_thr_i),
        .rd_iir_i(rd_iir_i), .rd_msr_i(rd_msr_i), .irq_o(irq_o), .id_o(id_o)
    );

    task automatic chk(input string tag, input logic [2:0] exp_id, input logic exp_irq);
        checks++;
        if (id_o !== exp_id || irq_o !== exp_irq) begin
            failures++;
            $display("FAIL %s: id=%b irq=%b expected id=%b irq=%b",
                     tag, id_o, irq_o, exp_id, exp_irq);
        end
    endtask

    // one rising edge, then release all single-cycle inputs
    task automatic cyc();
        @(negedge clk);
        ls_cond_i = '0; rx_ready_i = 0; tx_empty_i = 0; ms_chg_i = '0;
        rd_lsr_i = 0; rd_rbr_i = 0; wr_thr_i = 0; rd_iir_i = 0; rd_msr_i = 0;
    endtask

    task automatic t_reset();
        chk("R1 reset", 3'b001, 1'b0);
    endtask

    task automatic t_line();
        for (int b = 0; b < 4; b++) begin
            ls_cond_i[b] = 1'b1; cyc();
            chk("R4 line set", 3'b110, 1'b1);
            cyc();
            chk("R4 line held", 3'b110, 1'b1);
            rd_lsr_i = 1; cyc();
            chk("R4 line cleared", 3'b001, 1'b0);
        end
    endtask

    task automatic t_rxd();
        rx_ready_i = 1; cyc();
        chk("R5 rx set", 3'b100, 1'b1);
        wr_thr_i = 1; rd_msr_i = 1; cyc();
        chk("R5 rx ignores other strobes", 3'b100, 1'b1);
        rd_rbr_i = 1; cyc();
        chk("R5 rx cleared", 3'b001, 1'b0);
    endtask

    task automatic t_txe();
        tx_empty_i = 1; cyc();
        chk("R6 tx set", 3'b010, 1'b1);
        wr_thr_i = 1; cyc();
        chk("R6 tx cleared", 3'b001, 1'b0);
    endtask

    task automatic t_modem();
        for (int b = 0; b < 4; b++) begin
            ms_chg_i[b] = 1'b1; cyc();
            chk("R8 modem set, R2 bit0 low", 3'b000, 1'b1);
            rd_msr_i = 1; cyc();
            chk("R8 modem cleared", 3'b001, 1'b0);
        end
    endtask

    task automatic t_prio();
        ls_cond_i = 4'b0001; rx_ready_i = 1; tx_empty_i = 1; ms_chg_i = 4'b1000; cyc();
        chk("R3 line first", 3'b110, 1'b1);
        rd_lsr_i = 1; cyc();
        chk("R3 rx next", 3'b100, 1'b1);
        rd_rbr_i = 1; cyc();
        chk("R3 tx next", 3'b010, 1'b1);
        wr_thr_i = 1; cyc();
        chk("R3 modem last", 3'b000, 1'b1);
        rd_msr_i = 1; cyc();
        chk("R3 all clear", 3'b001, 1'b0);
    endtask

    task automatic t_iir();
        // tx hidden behind line status: a read must not clear it
        tx_empty_i = 1; ls_cond_i = 4'b0010; cyc();
        rd_iir_i = 1; cyc();
        chk("R7 read shows line", 3'b110, 1'b1);
        rd_lsr_i = 1; cyc();
        chk("R7 tx survived read", 3'b010, 1'b1);
        rd_iir_i = 1; cyc();
        chk("R7 tx cleared by read", 3'b001, 1'b0);
        // read reports 010 while a line event arrives in that cycle
        tx_empty_i = 1; cyc();
        rd_iir_i = 1; ls_cond_i = 4'b1000; cyc();
        chk("R7 same-cycle line event", 3'b110, 1'b1);
        rd_lsr_i = 1; cyc();
        chk("R7 tx gone after read", 3'b001, 1'b0);
        // disabled tx is not reported, so a read leaves it pending
        en_i = 4'b1011; tx_empty_i = 1; ms_chg_i = 4'b0001; cyc();
        rd_iir_i = 1; cyc();
        chk("R7 read shows modem", 3'b000, 1'b1);
        en_i = 4'hF; cyc();
        chk("R7 disabled tx kept", 3'b010, 1'b1);
        wr_thr_i = 1; rd_msr_i = 1; cyc();
        chk("R7 cleanup", 3'b001, 1'b0);
    endtask

    task automatic t_mask();
        en_i = 4'b0000; rx_ready_i = 1; ls_cond_i = 4'b0100; cyc();
        chk("R9 masked silent", 3'b001, 1'b0);
        cyc();
        en_i = 4'b0010; #1;
        chk("R9 enabled rx raises", 3'b100, 1'b1);
        en_i = 4'b0011; #1;
        chk("R9 enabled line outranks", 3'b110, 1'b1);
        rd_lsr_i = 1; rd_rbr_i = 1; en_i = 4'hF; cyc();
        chk("R9 cleanup", 3'b001, 1'b0);
    endtask

    task automatic t_timing();
        rx_ready_i = 1; #1;
        chk("R10 no raise before edge", 3'b001, 1'b0);
        cyc();
        chk("R10 raise after edge", 3'b100, 1'b1);
        rd_rbr_i = 1; #1;
        chk("R10 still high before edge", 3'b100, 1'b1);
        cyc();
        chk("R10 low after edge", 3'b001, 1'b0);
    endtask

    task automatic t_same();
        rx_ready_i = 1; rd_rbr_i = 1; cyc();
        chk("R11 set beats clear", 3'b100, 1'b1);
        rd_rbr_i = 1; cyc();
        chk("R11 cleanup", 3'b001, 1'b0);
    endtask

    initial begin
        #200000;
        if (!done) begin
            failures++;
            $display("FAIL watchdog: run hung, expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        cyc();
        t_reset();
        t_line();
        t_rxd();
        t_txe();
        t_modem();
        t_prio();
        t_iir();
        t_mask();
        t_timing();
        t_same();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule